// File: doc/BRIEF.md
# Cache Way Replacement Selector

This unit picks which way of an E-way set-associative cache gets evicted when a new line has to be brought in. The enclosing cache presents a set index on the replacement side. The unit answers with a victim way in the same cycle, taken from its current state. The cache also reports every hit and every fill as an access, giving the set and the way.

A static parameter chooses one of three policies:

- **Per-set FIFO.** Each set has its own circular pointer.
- **Shared pseudo-random.** One global wrapping counter serves all sets. A second parameter chooses when it steps: every clock, every access, or every replacement anywhere in the cache.
- **True LRU.** Each set keeps an ordered list of its ways. The first entry is the least recently used way and the last entry is the most recently used way.

Invalid-way preference, tags and data are left to the surrounding cache.

Top module: `repl_sel`

## Requirements
- R1: After a synchronous active-low reset, the victim is way 0 for every set under every policy. In LRU mode each set's usage order is 0,1,..,E-1, with way 0 the least recently used.
- R2: In FIFO mode, a replacement request on set s makes the victim for s step by one, wrapping from E-1 back to 0. Without such a request the victim for s is unchanged.
- R3: In FIFO mode, a set's pointer is untouched by replacements in other sets and by access notifications.
- R4: In random mode, the victim does not depend on the set index presented; all sets read the same shared counter.
- R5: In random mode the shared counter steps modulo E. With step mode CYCLE it steps on every clock. With step mode REF it steps on every cycle that has an access. With step mode REPL it steps on every cycle that has a replacement request.
- R6: In LRU mode the victim for a set is the way in that set that was accessed longest ago.
- R7: In LRU mode an access makes the accessed way the most recently used, so it is not the next victim. Replacement requests alone leave the usage order unchanged.
- R8: The victim shown in a cycle is computed from the state before that cycle. An access or replacement in the same cycle, even to the same set, takes effect only from the next cycle.
- R9: A counter that has reached E-1 returns to 0 on its next step, in both FIFO and random modes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| acc_vld | input | 1 | An access (hit or fill) occurs this cycle |
| acc_set | input | $clog2(SETS) | Set of the access |
| acc_way | input | $clog2(WAYS) | Way of the access |
| rep_req | input | 1 | A replacement occurs this cycle |
| rep_set | input | $clog2(SETS) | Set being asked about or replaced in |
| victim | output | $clog2(WAYS) | Way to evict in rep_set, from the current state |

## Verification
The bench builds five copies of the block, all with four ways and sixteen sets: one LRU, one FIFO, and one random copy for each of the three step modes. All five see the same stimulus, so every policy and every step schedule is compared cycle by cycle against its own bench model. Random set indices are often drawn from a narrow range. This makes accesses and replacements to the same set, often in the same cycle, frequent. Four ways are few enough that counter wrap and full reordering of an LRU list occur many times.

// File: rtl/repl_pkg.sv
// Shared types for the replacement selector: policy choice and
// the step schedule of the shared random counter.
package repl_pkg;
    typedef enum logic [1:0] {
        POL_FIFO = 2'd0,
        POL_RAND = 2'd1,
        POL_LRU  = 2'd2
    } policy_e;

    typedef enum logic [1:0] {
        STEP_CYCLE = 2'd0,
        STEP_REF   = 2'd1,
        STEP_REPL  = 2'd2
    } rstep_e;
endpackage

// File: rtl/repl_fifo.sv
// Per-set FIFO victim pointers.
// What it does: one wrapping pointer per set names the next way to evict;
// a replacement in a set moves that set's pointer on by one.
// Assumes: SETS is a power of two, WAYS >= 2.
module repl_fifo #(
    parameter int WAYS = 4,
    parameter int SETS = 16,
    localparam int WW = $clog2(WAYS),
    localparam int SW = $clog2(SETS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rep_req,
    input  logic [SW-1:0] rep_set,
    output logic [WW-1:0] victim
);
    logic [WW-1:0] ptr_q [SETS];

    function automatic logic [WW-1:0] wrap_inc(input logic [WW-1:0] x);
        return (x == WW'(WAYS - 1)) ? '0 : x + 1'b1;
    endfunction

    // Pointer storage: clear on reset, step the replaced set's pointer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < SETS; s++) ptr_q[s] <= '0;
        end else if (rep_req) begin
            ptr_q[rep_set] <= wrap_inc(ptr_q[rep_set]);
        end
    end

    // Victim read: pointer of the addressed set, before any update.
    always_comb victim = ptr_q[rep_set];
endmodule

// File: rtl/repl_rand.sv
// Shared pseudo-random victim counter.
// What it does: one wrapping counter names the victim for all sets; STEP
// picks whether it steps each clock, each access, or each replacement.
// Assumes: WAYS >= 2.
module repl_rand #(
    parameter int WAYS = 4,
    parameter repl_pkg::rstep_e STEP = repl_pkg::STEP_REPL,
    localparam int WW = $clog2(WAYS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          acc_vld,
    input  logic          rep_req,
    output logic [WW-1:0] victim
);
    logic [WW-1:0] cnt_q;
    logic          adv;
    logic          unused_ev;

    // Advance schedule chosen by parameter.
    generate
        if (STEP == repl_pkg::STEP_CYCLE) begin : g_cyc
            assign adv = 1'b1;
        end else if (STEP == repl_pkg::STEP_REF) begin : g_ref
            assign adv = acc_vld;
        end else begin : g_rep
            assign adv = rep_req;
        end
    endgenerate

    assign unused_ev = acc_vld ^ rep_req;

    // Counter: clear on reset, wrap at WAYS-1 on each advance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (adv) begin
            cnt_q <= (cnt_q == WW'(WAYS - 1)) ? '0 : cnt_q + 1'b1;
        end
    end

    // Victim read: the counter, for whichever set is asking.
    always_comb victim = cnt_q;
endmodule

// File: rtl/repl_lru.sv
// True LRU order lists.
// What it does: each set keeps its ways ordered from least (entry 0) to
// most (entry WAYS-1) recently used; an access moves the way to the top.
// Assumes: SETS is a power of two, WAYS >= 2, each list is a permutation.
module repl_lru #(
    parameter int WAYS = 4,
    parameter int SETS = 16,
    localparam int WW = $clog2(WAYS),
    localparam int SW = $clog2(SETS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          acc_vld,
    input  logic [SW-1:0] acc_set,
    input  logic [WW-1:0] acc_way,
    input  logic [SW-1:0] rep_set,
    output logic [WW-1:0] victim
);
    typedef logic [WAYS-1:0][WW-1:0] order_t;

    order_t ord_q [SETS];
    order_t ord_nxt;

    function automatic order_t promote(input order_t old, input logic [WW-1:0] w);
        order_t n;
        int     pos;
        pos = WAYS - 1;
        for (int i = 0; i < WAYS; i++) begin
            if (old[i] == w) pos = i;
        end
        for (int i = 0; i < WAYS - 1; i++) begin
            n[i] = (i < pos) ? old[i] : old[i+1];
        end
        n[WAYS-1] = w;
        return n;
    endfunction

    // Reordered list of the accessed set.
    always_comb ord_nxt = promote(ord_q[acc_set], acc_way);

    // List storage: identity order on reset, promote on access.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < SETS; s++) begin
                for (int i = 0; i < WAYS; i++) ord_q[s][i] <= WW'(i);
            end
        end else if (acc_vld) begin
            ord_q[acc_set] <= ord_nxt;
        end
    end

    // Victim read: least recently used entry of the addressed set.
    always_comb victim = ord_q[rep_set][0];
endmodule

// File: rtl/repl_sel.sv
// Replacement selector top.
// What it does: instantiates the policy engine chosen by POLICY and
// returns the victim way for rep_set in the same cycle.
// Assumes: accesses report hits and fills; the cache handles invalid ways.
module repl_sel #(
    parameter int WAYS = 4,
    parameter int SETS = 16,
    parameter repl_pkg::policy_e POLICY = repl_pkg::POL_LRU,
    parameter repl_pkg::rstep_e  STEP   = repl_pkg::STEP_REPL,
    localparam int WW = $clog2(WAYS),
    localparam int SW = $clog2(SETS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          acc_vld,
    input  logic [SW-1:0] acc_set,
    input  logic [WW-1:0] acc_way,
    input  logic          rep_req,
    input  logic [SW-1:0] rep_set,
    output logic [WW-1:0] victim
);
    generate
        if (POLICY == repl_pkg::POL_FIFO) begin : g_fifo
            logic unused_acc;
            assign unused_acc = ^{acc_vld, acc_set, acc_way};
            repl_fifo #(.WAYS(WAYS), .SETS(SETS)) u_eng (
                .clk(clk), .rst_n(rst_n), .rep_req(rep_req),
                .rep_set(rep_set), .victim(victim)
            );
        end else if (POLICY == repl_pkg::POL_RAND) begin : g_rand
            logic unused_idx;
            assign unused_idx = ^{acc_set, acc_way, rep_set};
            repl_rand #(.WAYS(WAYS), .STEP(STEP)) u_eng (
                .clk(clk), .rst_n(rst_n), .acc_vld(acc_vld),
                .rep_req(rep_req), .victim(victim)
            );
        end else begin : g_lru
            logic unused_rep;
            assign unused_rep = rep_req;
            repl_lru #(.WAYS(WAYS), .SETS(SETS)) u_eng (
                .clk(clk), .rst_n(rst_n), .acc_vld(acc_vld),
                .acc_set(acc_set), .acc_way(acc_way),
                .rep_set(rep_set), .victim(victim)
            );
        end
    endgenerate
endmodule

// File: rtl/repl_sel_chk.sv
// Assertion checker for repl_sel, bound to every instance.
// What it does: checks each policy's victim evolution over cycles.
// Assumes: same parameters as the bound instance.
module repl_sel_chk #(
    parameter int WAYS = 4,
    parameter int SETS = 16,
    parameter repl_pkg::policy_e POLICY = repl_pkg::POL_LRU,
    parameter repl_pkg::rstep_e  STEP   = repl_pkg::STEP_REPL,
    localparam int WW = $clog2(WAYS),
    localparam int SW = $clog2(SETS)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          acc_vld,
    input logic [SW-1:0] acc_set,
    input logic [WW-1:0] acc_way,
    input logic          rep_req,
    input logic [SW-1:0] rep_set,
    input logic [WW-1:0] victim
);
    logic past_ok;

    function automatic logic [WW-1:0] nx(input logic [WW-1:0] x);
        return (x == WW'(WAYS - 1)) ? '0 : x + 1'b1;
    endfunction

    // Marks cycles that have one cycle of history since reset.
    always_ff @(posedge clk) begin
        if (!rst_n) past_ok <= 1'b0;
        else        past_ok <= 1'b1;
    end

    generate
        if (POLICY == repl_pkg::POL_FIFO) begin : g_fifo
            // R2, R9: replacement on a set steps its victim with wrap
            a_r2_fifo_step: assert property (@(posedge clk) disable iff (!rst_n)
                (past_ok && $past(rep_req) && rep_set == $past(rep_set))
                |-> victim == nx($past(victim)));
            // R3: no replacement, no change for that set
            a_r3_fifo_hold: assert property (@(posedge clk) disable iff (!rst_n)
                (past_ok && !$past(rep_req) && rep_set == $past(rep_set))
                |-> $stable(victim));
        end else if (POLICY == repl_pkg::POL_RAND) begin : g_rand
            if (STEP == repl_pkg::STEP_CYCLE) begin : g_cyc
                // R5: steps every clock
                a_r5_rand_cycle: assert property (@(posedge clk) disable iff (!rst_n)
                    past_ok |-> victim == nx($past(victim)));
            end else if (STEP == repl_pkg::STEP_REF) begin : g_ref
                // R5, R4: steps on access cycles only, whatever the set
                a_r5_rand_ref: assert property (@(posedge clk) disable iff (!rst_n)
                    past_ok |-> victim == ($past(acc_vld) ? nx($past(victim)) : $past(victim)));
            end else begin : g_rep
                // R5, R4: steps on replacement cycles only, whatever the set
                a_r5_rand_repl: assert property (@(posedge clk) disable iff (!rst_n)
                    past_ok |-> victim == ($past(rep_req) ? nx($past(victim)) : $past(victim)));
            end
        end else begin : g_lru
            // R7: the way just accessed is not the victim of its set
            a_r7_lru_touched: assert property (@(posedge clk) disable iff (!rst_n)
                (past_ok && $past(acc_vld) && rep_set == $past(acc_set))
                |-> victim != $past(acc_way));
            // R7: without accesses the order holds
            a_r7_lru_hold: assert property (@(posedge clk) disable iff (!rst_n)
                (past_ok && !$past(acc_vld) && rep_set == $past(rep_set))
                |-> $stable(victim));
        end
    endgenerate
endmodule

bind repl_sel repl_sel_chk #(
    .WAYS(WAYS), .SETS(SETS), .POLICY(POLICY), .STEP(STEP)
) u_chk (
    .clk(clk), .rst_n(rst_n), .acc_vld(acc_vld), .acc_set(acc_set),
    .acc_way(acc_way), .rep_req(rep_req), .rep_set(rep_set), .victim(victim)
);

// File: tb/sim_repl_sel.sv
`timescale 1ns/1ps
module sim_repl_sel;
    localparam int WAYS = 4;
    localparam int SETS = 16;
    localparam int WW = $clog2(WAYS);
    localparam int SW = $clog2(SETS);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          acc_vld = 1'b0;
    logic [SW-1:0] acc_set = '0;
    logic [WW-1:0] acc_way = '0;
    logic          rep_req = 1'b0;
    logic [SW-1:0] rep_set = '0;
    logic [WW-1:0] v_lru, v_fifo, v_rref, v_rcyc, v_rrep;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    int fifo_m [SETS];
    int lru_m  [SETS][WAYS];
    int rc_cyc, rc_ref, rc_rep;

    always #5 clk = ~clk;

    repl_sel #(.WAYS(WAYS), .SETS(SETS), .POLICY(repl_pkg::POL_LRU)) u0 (
        .clk(clk), .rst_n(rst_n), .acc_vld(acc_vld), .acc_set(acc_set), .acc_way(acc_way),
        .rep_req(rep_req), .rep_set(rep_set), .victim(v_lru));
    repl_sel #(.WAYS(WAYS), .SETS(SETS), .POLICY(repl_pkg::POL_FIFO)) u1 (
        .clk(clk), .rst_n(rst_n), .acc_vld(acc_vld), .acc_set(acc_set), .acc_way(acc_way),
        .rep_req(rep_req), .rep_set(rep_set), .victim(v_fifo));
    repl_sel #(.WAYS(WAYS), .SETS(SETS), .POLICY(repl_pkg::POL_RAND),
               .STEP(repl_pkg::STEP_REF)) u2 (
        .clk(clk), .rst_n(rst_n), .acc_vld(acc_vld), .acc_set(acc_set), .acc_way(acc_way),
        .rep_req(rep_req), .rep_set(rep_set), .victim(v_rref));
    repl_sel #(.WAYS(WAYS), .SETS(SETS), .POLICY(repl_pkg::POL_RAND),
               .STEP(repl_pkg::STEP_CYCLE)) u3 (
        .clk(clk), .rst_n(rst_n), .acc_vld(acc_vld), .acc_set(acc_set), .acc_way(acc_way),
        .rep_req(rep_req), .rep_set(rep_set), .victim(v_rcyc));
    repl_sel #(.WAYS(WAYS), .SETS(SETS), .POLICY(repl_pkg::POL_RAND),
               .STEP(repl_pkg::STEP_REPL)) u4 (
        .clk(clk), .rst_n(rst_n), .acc_vld(acc_vld), .acc_set(acc_set), .acc_way(acc_way),
        .rep_req(rep_req), .rep_set(rep_set), .victim(v_rrep));

    function automatic int wrap(input int x);
        return (x == WAYS - 1) ? 0 : x + 1;
    endfunction

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: got %0d expected %0d at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic model_reset();
        for (int s = 0; s < SETS; s++) begin
            fifo_m[s] = 0;
            for (int i = 0; i < WAYS; i++) lru_m[s][i] = i;
        end
        rc_cyc = 0; rc_ref = 0; rc_rep = 0;
    endtask

    // Drive inputs, let them settle, compare every copy with its model.
    task automatic drive(input bit av, input int as, input int aw,
                         input bit rv, input int rs);
        acc_vld = av; acc_set = SW'(as); acc_way = WW'(aw);
        rep_req = rv; rep_set = SW'(rs);
        #1;
        chk("R6 lru victim",   int'(v_lru),  lru_m[rs][0]);
        chk("R2 fifo victim",  int'(v_fifo), fifo_m[rs]);
        chk("R5 rand ref",     int'(v_rref), rc_ref);
        chk("R5 rand cycle",   int'(v_rcyc), rc_cyc);
        chk("R5 rand repl",    int'(v_rrep), rc_rep);
    endtask

    // Take the clock edge, then update the models from the applied inputs.
    task automatic tick();
        int pos;
        @(posedge clk);
        rc_cyc = wrap(rc_cyc);
        if (acc_vld) rc_ref = wrap(rc_ref);
        if (rep_req) begin
            rc_rep = wrap(rc_rep);
            fifo_m[rep_set] = wrap(fifo_m[rep_set]);
        end
        if (acc_vld) begin
            pos = WAYS - 1;
            for (int i = 0; i < WAYS; i++) if (lru_m[acc_set][i] == int'(acc_way)) pos = i;
            for (int i = pos; i < WAYS - 1; i++) lru_m[acc_set][i] = lru_m[acc_set][i+1];
            lru_m[acc_set][WAYS-1] = int'(acc_way);
        end
        @(negedge clk);
    endtask

    task automatic report();
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    endtask

    initial begin
        #2000000;
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            report();
        end
    end

    initial begin
        int r4a;
        void'($urandom(32'h5eed));
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state in every set
        for (int s = 0; s < SETS; s++) begin
            drive(0, 0, 0, 0, s);
            chk("R1 lru reset", int'(v_lru), 0);
            chk("R1 fifo reset", int'(v_fifo), 0);
            chk("R1 rand reset", int'(v_rrep), 0);
            tick();
        end

        // R9 / R2: four replacements on set 7 wrap the counters
        for (int k = 0; k < 4; k++) begin
            drive(0, 0, 0, 1, 7);
            chk("R8 fifo old value", int'(v_fifo), k);
            tick();
        end
        drive(0, 0, 0, 0, 7);
        chk("R9 fifo wrap", int'(v_fifo), 0);
        chk("R9 rand repl wrap", int'(v_rrep), 0);
        chk("R5 rand ref idle", int'(v_rref), 0);
        tick();

        // R6: access ways 2 then 0 in set 3; order becomes 1,3,2,0
        drive(1, 3, 2, 0, 3); tick();
        drive(1, 3, 0, 0, 3); tick();
        drive(0, 0, 0, 0, 3);
        chk("R6 lru oldest", int'(v_lru), 1);
        chk("R3 fifo untouched by access", int'(v_fifo), 0);
        tick();

        // R7: replacements alone leave LRU order
        for (int k = 0; k < 3; k++) begin drive(0, 0, 0, 1, 3); tick(); end
        drive(0, 0, 0, 0, 3);
        chk("R7 lru hold", int'(v_lru), 1);
        chk("R3 other set after set 7", int'(v_fifo), 3);
        tick();

        // R8: access and replacement to set 3 in one cycle
        drive(1, 3, 1, 1, 3);
        chk("R8 lru old state", int'(v_lru), 1);
        tick();
        drive(0, 0, 0, 0, 3);
        chk("R8 lru after", int'(v_lru), 3);
        chk("R7 touched not victim", int'(v_lru != 1), 1);
        r4a = int'(v_rrep);
        tick();

        // R4: random victim identical for a different set
        drive(0, 0, 0, 0, 12);
        chk("R4 rand set-free", int'(v_rrep), r4a);
        chk("R3 fifo untouched set", int'(v_fifo), 0);
        tick();

        // Mixed random traffic, sets often narrow to collide
        for (int n = 0; n < 3000; n++) begin
            int as, rs;
            bit nar;
            nar = ($urandom % 2) == 0;
            as = nar ? int'($urandom % 3) : int'($urandom % SETS);
            rs = nar ? int'($urandom % 3) : int'($urandom % SETS);
            drive(($urandom % 3) != 0, as, int'($urandom % WAYS), ($urandom % 3) == 0, rs);
            tick();
        end

        done = 1'b1;
        report();
    end
endmodule